// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM burst. A start pulse delivers an 8-bit starting column along with a length code and an ordering flag. From the next clock on, the block presents one column per cycle. Each column comes with a beat-valid strobe. A last-beat strobe marks the final beat of a fixed-length burst.

Three orderings are supported. In sequential order, the column counts upward and wraps inside the aligned block that the length defines. In interleave order, the low bits are scrambled with XOR. In full-column order, the count runs through all columns and wraps with no natural end.

A burst can be ended early by a stop pulse, which also serves for a precharge, or by a fresh start pulse. A low clock enable freezes the burst one clock later. A data-mask input flags the beat as masked but never holds the count back.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o`, `mask_o` and `mode_err_o` are all low.
- R2: A start sampled at a clock edge (with the enable path live) puts the starting column on `col_o` with `valid_o` high in the following cycle.
- R3: Length code `len_i` is 000 for 1 beat, 001 for 2, 010 for 4 and 011 for 8. In sequential order, beat i carries the start's upper bits unchanged and low bits equal to (start + i) modulo the length. For example, start 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R4: With `ilv_i` high and a fixed length, beat i carries start XOR i. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: Any `len_i` with bit 2 set selects full-column order. In this order the column advances by one per beat, wraps from 255 to 0, never raises `last_o`, and continues until a stop or a new start.
- R6: `last_o` is high on exactly the final beat of a fixed-length burst, and `valid_o` is low in the cycle after it unless a new start was taken.
- R7: A `stop_i` pulse taken during a beat makes that beat the last one consumed; `valid_o` is low in the next cycle.
- R8: A start taken during a running burst ends it, and the next cycle shows the new burst's first column.
- R9: When `cke_i` is sampled low at an edge, the following edge does not advance the burst. During that cycle `valid_o` is low and `col_o` holds its value; the burst resumes one cycle after `cke_i` is sampled high again.
- R10: `dqm_i` does not change the column order or timing. `mask_o` equals `dqm_i` during a valid beat.
- R11: A start requesting interleave order with full-column length raises `mode_err_o` for the whole burst, and the burst runs in sequential full-column order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a burst (read or write command) |
| col_i | input | CW (8) | Starting column |
| len_i | input | 3 | Length code: 000=1, 001=2, 010=4, 011=8, 1xx=full column |
| ilv_i | input | 1 | 1 = interleave order, 0 = sequential |
| stop_i | input | 1 | End the running burst (burst stop or precharge) |
| cke_i | input | 1 | Clock enable; a low value suspends the next clock |
| dqm_i | input | 1 | Data mask for the current beat |
| col_o | output | CW (8) | Column address of the current beat |
| valid_o | output | 1 | A beat is presented and is consumed at the next edge |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |
| mask_o | output | 1 | Current beat is masked |
| mode_err_o | output | 1 | Running burst requested interleave with full-column length |

## Verification
The hardest case to reach is a suspension that lands in the middle of a burst. The clock enable acts one cycle late, so a low value changes nothing on the edge where it is sampled and freezes the edge after it. The stimulus drops `cke_i` after the second beat of a four-beat burst and holds it low for two edges. It then checks that the column shown during the frozen cycle is the third beat and stays unchanged. Chained starts and stop pulses are placed on chosen beat numbers. These include a full-column run that crosses column 255 and a burst ended by a new start, which make the interrupted paths observable.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] col_i,
  input  logic [2:0]    len_i,
  input  logic          ilv_i,
  input  logic          stop_i,
  input  logic          cke_i,
  input  logic          dqm_i,
  output logic [CW-1:0] col_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          mask_o,
  output logic          mode_err_o
);

  logic          act_q, cke_q, full_q, ilv_q, err_q;
  logic [CW-1:0] base_q, idx_q, blk_q;
  logic [CW-1:0] blk_d;
  logic          last_w;

  assign blk_d  = len_i[2] ? {CW{1'b1}} : CW'((4'd1 << len_i[1:0]) - 4'd1);
  assign last_w = act_q & ~full_q & (idx_q == blk_q);

  assign col_o      = ilv_q ? (base_q ^ idx_q)
                            : ((base_q & ~blk_q) | ((base_q + idx_q) & blk_q));
  assign valid_o    = act_q & cke_q;
  assign last_o     = valid_o & last_w;
  assign mask_o     = valid_o & dqm_i;
  assign mode_err_o = act_q & err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cke_q  <= 1'b1;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      blk_q  <= '0;
    end else begin
      cke_q <= cke_i;
      if (cke_q) begin
        if (start_i) begin
          act_q  <= 1'b1;
          base_q <= col_i;
          idx_q  <= '0;
          blk_q  <= blk_d;
          full_q <= len_i[2];
          ilv_q  <= ilv_i & ~len_i[2];
          err_q  <= ilv_i & len_i[2];
        end else if (act_q) begin
          if (stop_i || last_w) act_q <= 1'b0;
          else                  idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          stop_i,
  input logic          act_q,
  input logic          cke_q,
  input logic          full_q,
  input logic [CW-1:0] col_o,
  input logic          valid_o,
  input logic          last_o,
  input logic          mask_o,
  input logic          mode_err_o
);

  a_r6_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  a_r5_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full_q) |-> !last_o);

  a_r5_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full_q && !start_i && !stop_i) |=> (col_o == $past(col_o) + 1'b1));

  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  a_r9_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !cke_q) |=> (act_q && $stable(col_o)));

  a_r10_mask_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mask_o |-> valid_o);

  a_r11_err_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> act_q);

endmodule

bind burst_col_gen burst_col_gen_chk #(.CW(CW)) u_chk (.*);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] col_i = '0;
  logic [2:0] len_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       cke_i = 1'b1;
  logic       dqm_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, mask_o, mode_err_o;

  int tests = 0;
  int fails = 0;
  string cur_tag = "R3";
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen #(.CW(8)) u_dut (.*);

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int blen(logic [2:0] code);
    return code[2] ? 256 : (1 << code[1:0]);
  endfunction

  function automatic logic [7:0] exp_col(int start, logic [2:0] code, logic ilv, int i);
    int l, off;
    l = blen(code);
    if (ilv && !code[2]) return 8'(start ^ i);
    off = start % l;
    return 8'(start - off + (off + i) % l);
  endfunction

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check({cur_tag, " unexpected beat"}, 1, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({cur_tag, " column"}, col_o, e[7:0]);
        check("R6 last flag", last_o, e[8]);
      end
    end
  end

  // kind 0: natural end, 1: stop after k beats, 2: leave open for a chained start
  task automatic burst(string tag, int start, logic [2:0] code, logic ilv, int k, int kind);
    for (int i = 0; i < k; i++)
      exp_q.push_back({(!code[2] && i == blen(code) - 1), exp_col(start, code, ilv, i)});
    start_i = 1'b1; col_i = 8'(start); len_i = code; ilv_i = ilv;
    @(posedge clk); #1;
    cur_tag = tag;
    start_i = 1'b0;
    check("R2 first beat valid", valid_o, 1);
    check("R11 mode error flag", mode_err_o, int'(ilv && code[2]));
    repeat (k - 1) begin @(posedge clk); #1; end
    if (kind == 0) begin
      @(posedge clk); #1;
      check("R6 idle after last", valid_o, 0);
    end else if (kind == 1) begin
      stop_i = 1'b1;
      @(posedge clk); #1;
      stop_i = 1'b0;
      check("R7 idle after stop", valid_o, 0);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", valid_o, 0);
    check("R1 last in reset", last_o, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 valid after reset", valid_o, 0);
    check("R1 mask after reset", mask_o, 0);
    check("R1 err after reset", mode_err_o, 0);

    burst("R3 bl8 seq", 5, 3'b011, 1'b0, 8, 0);
    burst("R3 bl4 seq", 8'h2E, 3'b010, 1'b0, 4, 0);
    burst("R3 bl2 seq", 8'h81, 3'b001, 1'b0, 2, 0);
    burst("R3 bl1 seq", 8'hC7, 3'b000, 1'b0, 1, 0);
    burst("R4 bl8 ilv", 5, 3'b011, 1'b1, 8, 0);
    burst("R4 bl4 ilv", 8'h93, 3'b010, 1'b1, 4, 0);
    burst("R4 bl2 ilv", 8'h41, 3'b001, 1'b1, 2, 0);
    burst("R5 full wrap", 8'hFB, 3'b111, 1'b0, 12, 1);
    burst("R7 stop mid bl8", 8'h30, 3'b011, 1'b0, 3, 1);
    burst("R8 interrupted", 8'h16, 3'b011, 1'b0, 2, 2);
    burst("R8 new burst", 8'h6A, 3'b010, 1'b1, 4, 0);
    burst("R11 ilv full", 8'hFA, 3'b100, 1'b1, 10, 1);

    // R10: mask held high across an interleave burst
    dqm_i = 1'b1;
    exp_q.push_back({1'b0, 8'h55});
    start_i = 1'b1; col_i = 8'h55; len_i = 3'b011; ilv_i = 1'b1;
    for (int i = 1; i < 8; i++) exp_q.push_back({(i == 7), 8'(8'h55 ^ i)});
    @(posedge clk); #1;
    start_i = 1'b0; cur_tag = "R10 masked";
    check("R10 mask out", mask_o, 1);
    repeat (8) begin @(posedge clk); #1; end
    check("R10 idle after masked burst", valid_o, 0);
    check("R10 mask idle", mask_o, 0);
    dqm_i = 1'b0;

    // R9: suspend in the middle of a length-4 burst from column 2
    for (int i = 0; i < 4; i++) exp_q.push_back({(i == 3), exp_col(2, 3'b010, 1'b0, i)});
    start_i = 1'b1; col_i = 8'd2; len_i = 3'b010; ilv_i = 1'b0;
    @(posedge clk); #1;
    start_i = 1'b0; cur_tag = "R9 suspended";
    @(posedge clk); #1;
    cke_i = 1'b0;
    @(posedge clk); #1;
    check("R9 valid low in suspend", valid_o, 0);
    check("R9 column during suspend", col_o, 0);
    @(posedge clk); #1;
    check("R9 still suspended", valid_o, 0);
    check("R9 column held", col_o, 0);
    cke_i = 1'b1;
    @(posedge clk); #1;
    check("R9 resumed", valid_o, 1);
    check("R9 resumed column", col_o, 0);
    repeat (2) begin @(posedge clk); #1; end
    check("R9 idle after burst", valid_o, 0);

    repeat (3) @(posedge clk);
    check("R2 all beats seen", exp_q.size(), 0);
    finish_run();
  end
endmodule